// File: doc/BRIEF.md
# Three-Stage RISC Pipeline Controller

This block runs a small 16-bit RISC core as three overlapped stages: fetch, execute and writeback. An instruction register closes the fetch stage. A result register, together with a writeback control register that keeps the destination and the kind of write, closes the execute stage. The register bank or memory takes the result at the end of writeback. One memory port serves both instruction fetch and data access. When a load or store reaches writeback it takes the port for that cycle. Fetch then pauses, and a bubble enters execute.

The core has no forwarding and no hazard interlock. Software must keep dependent instructions at least one slot apart. It must also fill the two slots after a branch, because those slots always complete. Debug outputs show the fetch address register and the stall condition.

Top module: `pipe3_core`

## Requirements
- R1: While reset is asserted, dbg_pc is 0, dbg_stall is 0, mem_we is 0 and mem_addr is 0. Both pipeline registers hold the all-zeros word.
- R2: From an empty pipe, the first instruction writes back in the third clock cycle. In every cycle without a stall or redirect, the fetch address advances by one word.
- R3: An instruction is op[15:13], d[12:10], a[9:7], and either b[6:4] or a signed imm[6:0]. Opcodes: 0 add, 1 sub, 2 and, 3 or (d = a op b), 4 load, 5 store, 6 branch-if-zero, 7 does nothing.
- R4: The word 0x0000 is a no-operation. It writes no register and no memory.
- R5: Register 0 always reads as zero. Writes to it are discarded.
- R6: There is no bypass. An instruction that reads a register written by the instruction just before it sees the old value.
- R7: Branch-if-zero tests register a. When that register is zero, the two instructions after the branch still complete, and fetch then continues at branch address + 1 + imm.
- R8: A load or store uses memory in its writeback cycle. In that cycle dbg_stall is 1 and mem_addr is the data address. The fetch address and the instruction register hold, and fetch resumes on the next clock.
- R9: A stall cycle feeds a bubble into execute. The held instruction executes once, and dbg_stall is never high in two consecutive cycles.
- R10: A store drives mem_we high for exactly its writeback cycle, with mem_wdata equal to register d.
- R11: Load and store addresses are register a + imm. A load writes the memory word into register d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Shared memory address: fetch or data |
| mem_rdata | input | 16 | Memory read data, combinational from mem_addr |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store write enable |
| dbg_pc | output | 16 | Fetch address register |
| dbg_stall | output | 1 | High in a load/store writeback cycle |

## Verification
On every cycle, the assertions check the following:
- the fetch address holds across a stall and steps by one otherwise;
- a pending redirect lands on its target;
- stalls never come back to back;
- register 0 stays zero.

Only the program scenario can show the rest:
- the register values each instruction produces;
- the old value seen by the hazard slot;
- that both branch slots complete while the third instruction after the branch is skipped;
- that the branch falls through on a non-zero register.

The bench checks these by comparing the ports against a behavioural model on every clock, and by reading back stored results.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
    localparam int XW     = 16;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;
    localparam int IMM_W  = 7;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
        OP_LD  = 3'd4, OP_ST  = 3'd5, OP_BZ  = 3'd6, OP_RSV = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WB_NONE = 2'd0, WB_REG = 2'd1, WB_LOAD = 2'd2, WB_STORE = 2'd3
    } wb_e;

    typedef struct packed {
        wb_e               kind;
        logic [RIDX_W-1:0] rd;
        logic [XW-1:0]     sdata;
    } wbctl_t;

    typedef struct packed {
        logic [XW-1:0] pc;
        logic [XW-1:0] ir;
        logic [XW-1:0] res;
        wbctl_t        wb;
        logic          rv;
        logic [XW-1:0] rt;
    } pipe_t;

    function automatic logic [XW-1:0] sext_imm(input logic [XW-1:0] w);
        return {{(XW-IMM_W){w[IMM_W-1]}}, w[IMM_W-1:0]};
    endfunction
endpackage

// File: rtl/p3_regbank.sv
module p3_regbank
    import pipe3_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [RIDX_W-1:0]           waddr,
    input  logic [XW-1:0]               wdata,
    input  logic [NRD-1:0][RIDX_W-1:0]  raddr,
    output logic [NRD-1:0][XW-1:0]      rdata
);
    logic [XW-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs_q[raddr[g]];
    end

    // R5
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) regs_q[0] == '0);
endmodule

// File: rtl/p3_exec.sv
module p3_exec
    import pipe3_pkg::*;
(
    input  logic [XW-1:0]     ir,
    input  logic [XW-1:0]     pc_next,
    output logic [RIDX_W-1:0] sel_a,
    output logic [RIDX_W-1:0] sel_b,
    output logic [RIDX_W-1:0] sel_d,
    input  logic [XW-1:0]     val_a,
    input  logic [XW-1:0]     val_b,
    input  logic [XW-1:0]     val_d,
    output logic [XW-1:0]     res,
    output wbctl_t            wb,
    output logic              redir,
    output logic [XW-1:0]     target
);
    op_e           op;
    logic [XW-1:0] imm;

    assign op    = op_e'(ir[15:13]);
    assign sel_d = ir[12:10];
    assign sel_a = ir[9:7];
    assign sel_b = ir[6:4];
    assign imm   = sext_imm(ir);

    always_comb begin
        res      = '0;
        wb.kind  = WB_NONE;
        wb.rd    = sel_d;
        wb.sdata = val_d;
        redir    = 1'b0;
        target   = pc_next + imm;
        unique case (op)
            OP_ADD: begin res = val_a + val_b; wb.kind = WB_REG; end
            OP_SUB: begin res = val_a - val_b; wb.kind = WB_REG; end
            OP_AND: begin res = val_a & val_b; wb.kind = WB_REG; end
            OP_OR:  begin res = val_a | val_b; wb.kind = WB_REG; end
            OP_LD:  begin res = val_a + imm;   wb.kind = WB_LOAD; end
            OP_ST:  begin res = val_a + imm;   wb.kind = WB_STORE; end
            OP_BZ:  redir = (val_a == '0);
            default: ;
        endcase
    end
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
    import pipe3_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [15:0]   mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   mem_wdata,
    output logic          mem_we,
    output logic [15:0]   dbg_pc,
    output logic          dbg_stall
);
    localparam int NRD = 3;

    pipe_t p_q, p_d;

    logic                       stall;
    logic                       rf_we;
    logic [XW-1:0]              rf_wd;
    logic [NRD-1:0][RIDX_W-1:0] rf_ra;
    logic [NRD-1:0][XW-1:0]     rf_rd;
    logic [XW-1:0]              ex_res;
    wbctl_t                     ex_wb;
    logic                       ex_rv;
    logic [XW-1:0]              ex_rt;

    p3_regbank #(.NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (p_q.wb.rd),
        .wdata (rf_wd),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    p3_exec u_ex (
        .ir      (p_q.ir),
        .pc_next (p_q.pc),
        .sel_a   (rf_ra[0]),
        .sel_b   (rf_ra[1]),
        .sel_d   (rf_ra[2]),
        .val_a   (rf_rd[0]),
        .val_b   (rf_rd[1]),
        .val_d   (rf_rd[2]),
        .res     (ex_res),
        .wb      (ex_wb),
        .redir   (ex_rv),
        .target  (ex_rt)
    );

    // Writeback and shared memory port
    assign stall     = (p_q.wb.kind == WB_LOAD) || (p_q.wb.kind == WB_STORE);
    assign mem_addr  = stall ? p_q.res : p_q.pc;
    assign mem_we    = (p_q.wb.kind == WB_STORE);
    assign mem_wdata = p_q.wb.sdata;
    assign rf_we     = (p_q.wb.kind == WB_REG) || (p_q.wb.kind == WB_LOAD);
    assign rf_wd     = (p_q.wb.kind == WB_LOAD) ? mem_rdata : p_q.res;
    assign dbg_pc    = p_q.pc;
    assign dbg_stall = stall;

    always_comb begin
        p_d = p_q;
        if (stall) begin
            // port busy with data: hold fetch, bubble into writeback
            p_d.wb.kind = WB_NONE;
        end else begin
            p_d.ir  = mem_rdata;
            p_d.pc  = p_q.rv ? p_q.rt : p_q.pc + 16'd1;
            p_d.res = ex_res;
            p_d.wb  = ex_wb;
            p_d.rv  = ex_rv;
            p_d.rt  = ex_rt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // R8
    stall_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_stall |=> dbg_pc == $past(dbg_pc));
    // R9
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_stall |=> !dbg_stall);
    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_stall && !p_q.rv) |=> dbg_pc == $past(dbg_pc) + 16'd1);
    // R7
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_stall && p_q.rv) |=> dbg_pc == $past(p_q.rt));
endmodule

// File: tb/pipe3_core_tb.sv
module pipe3_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, mem_wdata, dbg_pc;
    logic        mem_we, dbg_stall;

    int nchk = 0;
    int nfail = 0;
    int nwrites = 0;
    bit done = 1'b0;

    logic [15:0] mem [256];

    always #4 clk = ~clk;

    pipe3_core u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_stall(dbg_stall)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            nwrites <= nwrites + 1;
        end
    end

    // reference model state
    logic [15:0] m_pc, m_ir, m_res, m_sd, m_rt;
    logic [1:0]  m_wbk;
    logic [2:0]  m_wbrd;
    logic        m_rv;
    logic [15:0] rg [8];
    logic [15:0] mm [256];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int d, input int a, input int low7);
        logic [15:0] w;
        w = {op[2:0], d[2:0], a[2:0], low7[6:0]};
        return w;
    endfunction

    function automatic logic [15:0] alu(input int op, input int d, input int a, input int b);
        return enc(op, d, a, b << 4);
    endfunction

    task automatic model_step();
        logic        stl;
        logic [15:0] ir, sx, va, vb, vd, nres, nsd, nrt, nir, npc;
        logic [1:0]  nk;
        logic        nrv;
        int          op;
        stl = (m_wbk == 2'd2) || (m_wbk == 2'd3);
        ir  = m_ir;
        op  = int'(ir[15:13]);
        sx  = {{9{ir[6]}}, ir[6:0]};
        va  = rg[ir[9:7]];
        vb  = rg[ir[6:4]];
        vd  = rg[ir[12:10]];
        nres = 16'd0; nk = 2'd0; nrv = 1'b0; nsd = vd; nrt = m_pc + sx;
        case (op)
            0: begin nres = va + vb; nk = 2'd1; end
            1: begin nres = va - vb; nk = 2'd1; end
            2: begin nres = va & vb; nk = 2'd1; end
            3: begin nres = va | vb; nk = 2'd1; end
            4: begin nres = va + sx; nk = 2'd2; end
            5: begin nres = va + sx; nk = 2'd3; end
            6: nrv = (va == 16'd0);
            default: ;
        endcase
        nir = mm[m_pc[7:0]];
        npc = m_rv ? m_rt : m_pc + 16'd1;
        // writeback of the older instruction
        if (m_wbk == 2'd1 && m_wbrd != 3'd0) rg[m_wbrd] = m_res;
        if (m_wbk == 2'd2 && m_wbrd != 3'd0) rg[m_wbrd] = mm[m_res[7:0]];
        if (m_wbk == 2'd3) mm[m_res[7:0]] = m_sd;
        if (stl) begin
            m_wbk = 2'd0;
        end else begin
            m_ir = nir; m_pc = npc; m_res = nres; m_wbk = nk;
            m_wbrd = ir[12:10]; m_sd = nsd; m_rv = nrv; m_rt = nrt;
        end
    endtask

    task automatic compare_ports();
        logic stl;
        stl = (m_wbk == 2'd2) || (m_wbk == 2'd3);
        chk("R2 dbg_pc", dbg_pc, m_pc);
        chk("R8 dbg_stall", {15'd0, dbg_stall}, {15'd0, stl});
        chk("R8 mem_addr", mem_addr, stl ? m_res : m_pc);
        chk("R10 mem_we", {15'd0, mem_we}, {15'd0, (m_wbk == 2'd3)});
        if (m_wbk == 2'd3) chk("R10 mem_wdata", mem_wdata, m_sd);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = 16'd0;
        mem[8'h30] = 16'd5;
        mem[8'h31] = 16'd3;
        mem[0]  = enc(4, 1, 0, 'h30);   // R11 load r1
        mem[1]  = enc(4, 2, 0, 'h31);   // R11 load r2
        mem[2]  = 16'h0000;             // R4 nop
        mem[3]  = alu(0, 3, 1, 2);      // R3 add -> 8
        mem[4]  = alu(1, 4, 1, 2);      // R3 sub -> 2
        mem[5]  = alu(2, 5, 1, 2);      // R3 and -> 1
        mem[6]  = alu(3, 6, 1, 2);      // R3 or  -> 7
        mem[7]  = alu(0, 7, 6, 0);      // R6 reads old r6 = 0
        mem[8]  = alu(0, 0, 1, 1);      // R5 write to r0 discarded
        mem[9]  = enc(5, 3, 0, 'h38);
        mem[10] = enc(5, 4, 0, 'h39);
        mem[11] = enc(5, 5, 0, 'h3A);
        mem[12] = enc(5, 6, 0, 'h3B);
        mem[13] = enc(5, 7, 0, 'h3C);
        mem[14] = enc(5, 0, 0, 'h3D);
        mem[15] = enc(6, 0, 0, 3);      // R7 taken to 19
        mem[16] = alu(0, 7, 1, 1);      // slot 1: r7 = 10
        mem[17] = alu(0, 4, 2, 2);      // slot 2: r4 = 6
        mem[18] = alu(0, 5, 1, 1);      // skipped
        mem[19] = enc(6, 0, 1, 5);      // R7 not taken (r1 = 5)
        mem[20] = enc(5, 7, 0, 'h3E);
        mem[21] = enc(5, 4, 0, 'h3F);
        mem[22] = enc(5, 5, 0, 'h37);
        mem[23] = enc(6, 0, 0, 'h7F);   // spin on itself
        for (int i = 0; i < 256; i++) mm[i] = mem[i];
        for (int i = 0; i < 8; i++) rg[i] = 16'd0;
        m_pc = 0; m_ir = 0; m_res = 0; m_sd = 0; m_rt = 0; m_wbk = 0; m_wbrd = 0; m_rv = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 dbg_pc", dbg_pc, 16'd0);
        chk("R1 dbg_stall", {15'd0, dbg_stall}, 16'd0);
        chk("R1 mem_we", {15'd0, mem_we}, 16'd0);
        chk("R1 mem_addr", mem_addr, 16'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 120; c++) begin
            #1;
            compare_ports();
            model_step();
            @(negedge clk);
        end
        // architectural results observed through stores
        chk("R3 add", mem[8'h38], 16'd8);
        chk("R3 sub", mem[8'h39], 16'd2);
        chk("R3 and", mem[8'h3A], 16'd1);
        chk("R3 or", mem[8'h3B], 16'd7);
        chk("R6 no bypass", mem[8'h3C], 16'd0);
        chk("R5 r0 zero", mem[8'h3D], 16'd0);
        chk("R7 slot1", mem[8'h3E], 16'd10);
        chk("R7 slot2", mem[8'h3F], 16'd6);
        chk("R7 skipped", mem[8'h37], 16'd1);
        chk("R11 load kept", mem[8'h30], 16'd5);
        chk("R4 store count", nwrites[15:0], 16'd9);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule